// File: doc/BRIEF.md
# Cascaded Programmable Decimation Filter

This block lowers the rate of a stream of 16-bit converter samples that arrive at a fixed base rate. It passes them through two averaging stages in series. Each stage sums a run-time programmable number of accepted samples, N, from 1 to 128. When the window is complete it emits the rounded mean, then clears and starts the next window. The output rate is therefore the base rate divided by N1 x N2. A 10 x 10 or 100 x 1 setting turns a 1000 sample/s stream into 10 sample/s, with averaging nulls at every multiple of 10 Hz. That setting covers both 50 Hz and 60 Hz mains.

Software programs the stage lengths and a bypass flag through a small write port. Every write restarts both windows, so no output mixes samples taken under two settings. In bypass the raw stream is forwarded with one cycle of delay. The mean is formed with a reciprocal multiply. The reciprocals are computed when the design is elaborated, and the result is exact for any window length.

Top module: `decim_cascade`

## Requirements
- R1: After reset, out_valid is low, bypass is off and both stage length codes are 0, so N1 = N2 = 1 and every accepted sample passes through.
- R2: A cycle with cfg_wr high writes one setting, selected by cfg_sel. Value 0 sets the first stage's length code, and value 1 sets the second stage's. In both cases the code is cfg_wdata[6:0] and N = code + 1. Value 2 sets bypass from cfg_wdata[0]. Value 3 changes no setting.
- R3: Each stage emits floor((S + floor(N/2)) / N), where S is the exact sum of its N accepted samples. The sum carries enough extra bits that this holds for every input.
- R4: The second stage counts only the first stage's output strobes, so the block gives one output per N1 x N2 accepted input samples. An input that completes both windows appears on out_valid/out_data two cycles after the cycle in which it is presented.
- R5: A stage with N = 1 forwards each accepted sample unchanged, one cycle later.
- R6: Cycles with in_valid low have no effect on the sums or on the window counts. The first stage raises its strobe only in the cycle after an accepted input.
- R7: Every cfg_wr cycle discards partial sums and window counts in both stages. out_valid is low in the following cycle, and the next output comes only after a complete new N1 x N2 window.
- R8: With bypass on, each input with in_valid high appears on out_data with out_valid high one cycle later, and out_valid stays low after idle input cycles.
- R9: With N = 128 and every sample at 0xFFFF, the output is exactly 0xFFFF, with no overflow or loss.
- R10: With lengths that multiply to 100, the block produces the exact rounded two-stage average at one hundredth of the input rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr | input | 1 | Setting write strobe; each strobe also restarts the windows |
| cfg_sel | input | 2 | Setting select: 0 first length, 1 second length, 2 bypass, 3 none |
| cfg_wdata | input | 7 | Length code (N-1), or bypass flag in bit 0 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Unsigned input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Filtered or bypassed sample |

## Verification
The checker watches four things on every cycle. The output must fall quiet after any setting write. Bypass must echo the input one cycle later and stay silent otherwise. Every non-bypass output must be preceded by a first-stage strobe, and every first-stage strobe by an accepted input. Only the bench scenarios can show the arithmetic: the rounded means for odd lengths, the 10 x 10 and 100 x 1 settings, full-scale sums, and the exact output count per window after a mid-window restart. A reference model in the bench computes these from the sample values it sends.

// File: rtl/decim_pkg.sv
package decim_pkg;

  // Smallest multiplier m with m * n >= 2**k; used to replace division by n.
  function automatic longint unsigned recip_ceil(input int unsigned n, input int unsigned k);
    longint unsigned one_k;
    one_k = 64'd1 << k;
    return (one_k + longint'(n) - 64'd1) / longint'(n);
  endfunction

endpackage

// File: rtl/decim_stage.sv
module decim_stage #(
  parameter int DW   = 16,
  parameter int MAXN = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [$clog2(MAXN)-1:0]   len_code,
  input  logic                      in_valid,
  input  logic [DW-1:0]             in_data,
  output logic                      out_valid,
  output logic [DW-1:0]             out_data
);
  localparam int CW = $clog2(MAXN);
  localparam int AW = DW + CW;       // exact sum of up to MAXN samples
  localparam int XW = AW + 1;        // sum plus rounding term
  localparam int K  = XW + CW;       // reciprocal scaling, exact for XW-bit numerators
  localparam int MW = K + 1;
  localparam int PW = XW + MW;

  logic [MW-1:0] recip_rom [MAXN];

  for (genvar g = 0; g < MAXN; g++) begin : g_recip
    assign recip_rom[g] = MW'(decim_pkg::recip_ceil(g + 1, K));
  end

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] acc_q, acc_d;
  logic          ov_q, ov_d;
  logic [DW-1:0] od_q, od_d;

  logic [AW-1:0] sum;
  logic [CW:0]   nlen;
  logic [XW-1:0] numer;
  logic [PW-1:0] prod;
  logic          last;

  always_comb begin
    nlen  = {1'b0, len_code} + (CW+1)'(1);
    sum   = acc_q + AW'(in_data);
    numer = XW'(sum) + XW'(nlen >> 1);
    prod  = PW'(numer) * PW'(recip_rom[len_code]);
    last  = (cnt_q == len_code);
  end

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    ov_d  = 1'b0;
    od_d  = od_q;
    if (flush) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (in_valid) begin
      if (last) begin
        cnt_d = '0;
        acc_d = '0;
        ov_d  = 1'b1;
        od_d  = prod[K +: DW];
      end else begin
        cnt_d = cnt_q + CW'(1);
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      ov_q  <= 1'b0;
      od_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      ov_q  <= ov_d;
      od_q  <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

endmodule

// File: rtl/decim_cfg.sv
module decim_cfg #(
  parameter int NST = 2,
  parameter int CW  = 7,
  parameter int SW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [SW-1:0] cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] len_code [NST],
  output logic          bypass,
  output logic          flush
);
  logic [CW-1:0] len_q [NST];
  logic [CW-1:0] len_d [NST];
  logic          byp_q, byp_d;

  always_comb begin
    for (int i = 0; i < NST; i++) len_d[i] = len_q[i];
    byp_d = byp_q;
    if (cfg_wr) begin
      for (int i = 0; i < NST; i++) begin
        if (cfg_sel == SW'(i)) len_d[i] = cfg_wdata;
      end
      if (cfg_sel == SW'(NST)) byp_d = cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) len_q[i] <= '0;
      byp_q <= 1'b0;
    end else begin
      for (int i = 0; i < NST; i++) len_q[i] <= len_d[i];
      byp_q <= byp_d;
    end
  end

  assign len_code = len_q;
  assign bypass   = byp_q;
  assign flush    = cfg_wr;

endmodule

// File: rtl/decim_cascade.sv
module decim_cascade #(
  parameter int DW   = 16,
  parameter int MAXN = 128,
  parameter int NST  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [$clog2(NST+1)-1:0]    cfg_sel,
  input  logic [$clog2(MAXN)-1:0]     cfg_wdata,
  input  logic                        in_valid,
  input  logic [DW-1:0]               in_data,
  output logic                        out_valid,
  output logic [DW-1:0]               out_data
);
  localparam int CW = $clog2(MAXN);
  localparam int SW = $clog2(NST + 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic [CW-1:0] len_code [NST];
  logic          byp_q;
  logic          flush;

  decim_cfg #(.NST(NST), .CW(CW), .SW(SW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_s),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .len_code (len_code),
    .bypass   (byp_q),
    .flush    (flush)
  );

  logic          stg_vld [NST+1];
  logic [DW-1:0] stg_dat [NST+1];

  assign stg_vld[0] = in_valid & ~byp_q;
  assign stg_dat[0] = in_data;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    decim_stage #(.DW(DW), .MAXN(MAXN)) u_stage (
      .clk      (clk),
      .rst_n    (rst_s),
      .flush    (flush),
      .len_code (len_code[g]),
      .in_valid (stg_vld[g]),
      .in_data  (stg_dat[g]),
      .out_valid(stg_vld[g+1]),
      .out_data (stg_dat[g+1])
    );
  end

  // bypass path: one register stage
  logic          bv_q, bv_d;
  logic [DW-1:0] bd_q, bd_d;

  always_comb begin
    bv_d = in_valid & byp_q & ~flush;
    bd_d = (in_valid & byp_q) ? in_data : bd_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      bv_q <= 1'b0;
      bd_q <= '0;
    end else begin
      bv_q <= bv_d;
      bd_q <= bd_d;
    end
  end

  assign out_valid = byp_q ? bv_q : stg_vld[NST];
  assign out_data  = byp_q ? bd_q : stg_dat[NST];

endmodule

// File: rtl/decim_cascade_chk.sv
module decim_cascade_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_s,
  input logic          cfg_wr,
  input logic          bypass,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          s1_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_wr |=> !out_valid);  // R7

  AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rst_s)
    (bypass && $past(bypass) && $past(in_valid) && !$past(cfg_wr))
      |-> (out_valid && out_data == $past(in_data)));  // R8

  AST_BYPASS_SILENT: assert property (@(posedge clk) disable iff (!rst_s)
    (bypass && !$past(in_valid)) |-> !out_valid);  // R8

  AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_s)
    (!bypass && out_valid) |-> $past(s1_valid));  // R4

  AST_STAGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_s)
    s1_valid |-> $past(in_valid && !bypass));  // R6

endmodule

bind decim_cascade decim_cascade_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .cfg_wr   (cfg_wr),
  .bypass   (byp_q),
  .in_valid (in_valid),
  .in_data  (in_data),
  .s1_valid (stg_vld[1]),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/decim_cascade_test.sv
`timescale 1ns/1ps
module decim_cascade_test;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [6:0]  cfg_wdata;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid;
  logic [15:0] out_data;

  decim_cascade uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  longint m_acc [2];
  int     m_cnt [2];
  int     m_n   [2];
  bit     m_byp;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      m_acc[i] = 0;
      m_cnt[i] = 0;
    end
  endtask

  task automatic model(input logic [15:0] d, input string tag);
    longint v;
    if (m_byp) begin
      exp_q.push_back(d);
      tag_q.push_back(tag);
    end else begin
      m_acc[0] += d;
      m_cnt[0]++;
      if (m_cnt[0] == m_n[0]) begin
        v = (m_acc[0] + m_n[0] / 2) / m_n[0];
        m_acc[0] = 0; m_cnt[0] = 0;
        m_acc[1] += v;
        m_cnt[1]++;
        if (m_cnt[1] == m_n[1]) begin
          v = (m_acc[1] + m_n[1] / 2) / m_n[1];
          m_acc[1] = 0; m_cnt[1] = 0;
          exp_q.push_back(v[15:0]);
          tag_q.push_back(tag);
        end
      end
    end
  endtask

  task automatic idle(input int k);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [6:0] val);
    @(negedge clk);
    in_valid  = 1'b0;
    cfg_wr    = 1'b1;
    cfg_sel   = sel;
    cfg_wdata = val;
    if (sel == 2'd0) m_n[0] = int'(val) + 1;
    if (sel == 2'd1) m_n[1] = int'(val) + 1;
    if (sel == 2'd2) m_byp = val[0];
    model_clear();
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send(input logic [15:0] d, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    model(d, tag);
  endtask

  task automatic send_rand(input int count, input bit gaps, input string tag);
    for (int i = 0; i < count; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 16'($urandom);
      end
      send(16'($urandom), tag);
    end
  endtask

  task automatic drain(input string tag);
    idle(8);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // monitor: compare every output against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R7 unexpected output", out_data, -1);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, out_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0;
    m_n[0] = 1; m_n[1] = 1; m_byp = 1'b0;
    model_clear();
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);

    // R1/R5: default lengths pass samples straight through
    for (int i = 0; i < 8; i++) send(16'(i * 4099 + 7), "R1/R5 default pass");
    drain("R1/R5 drain");

    // R4: latency of two cycles with N1 = N2 = 1
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'h1234; model(16'h1234, "R4 latency data");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R4 latency early", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R4 latency on time", out_valid, 1);
    drain("R4 drain");

    // R2/R3/R6: odd lengths 3 and 7 with idle gaps
    cfg_write(2'd0, 7'd2);
    cfg_write(2'd1, 7'd6);
    send_rand(84, 1'b1, "R3/R6 lengths 3x7");
    drain("R3 drain");

    // R10: 10 x 10
    cfg_write(2'd0, 7'd9);
    cfg_write(2'd1, 7'd9);
    send_rand(300, 1'b1, "R10 lengths 10x10");
    drain("R10 drain 10x10");

    // R10: 100 x 1
    cfg_write(2'd0, 7'd99);
    cfg_write(2'd1, 7'd0);
    send_rand(300, 1'b0, "R10 lengths 100x1");
    drain("R10 drain 100x1");

    // R9: full-scale sums at the longest window
    cfg_write(2'd0, 7'd127);
    cfg_write(2'd1, 7'd1);
    for (int i = 0; i < 256; i++) send(16'hFFFF, "R9 full scale");
    drain("R9 drain");
    cfg_write(2'd0, 7'd0);
    cfg_write(2'd1, 7'd127);
    send_rand(256, 1'b1, "R3 lengths 1x128");
    drain("R3 drain 1x128");

    // R7: a write in mid-window discards the partial sums
    cfg_write(2'd0, 7'd3);
    cfg_write(2'd1, 7'd3);
    send_rand(7, 1'b0, "R7 partial");
    cfg_write(2'd0, 7'd3);
    send_rand(16, 1'b1, "R7 full window after restart");
    drain("R7 drain");

    // R2: select 3 changes no setting but still restarts
    send_rand(5, 1'b0, "R2 partial");
    cfg_write(2'd3, 7'h55);
    send_rand(16, 1'b0, "R2 select 3 keeps 4x4");
    drain("R2 drain");

    // R8: bypass echo with gaps, then back to filtering
    cfg_write(2'd2, 7'd1);
    send_rand(12, 1'b1, "R8 bypass echo");
    drain("R8 drain");
    cfg_write(2'd2, 7'd0);
    send_rand(32, 1'b1, "R8 bypass off 4x4");
    drain("R8 drain off");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule